// File: doc/BRIEF.md
# Alarm Match and Interrupt Flag Controller

This block sits beside a time-of-day counter. Each time the counter finishes a one-second update, the block compares the current hours, minutes and seconds bytes with three stored alarm bytes. An alarm byte whose top two bits are both 1 acts as a wildcard for its field, so the same comparator serves daily, hourly, per-minute and per-second alarms.

The block gathers three event sources into a status byte: the periodic tick, the alarm match and the end of an update. Software clears that byte by reading it. Each event has an enable bit in a small control byte. Whenever an enabled event is pending, the block asserts a pull-low request for an open-drain interrupt line. Otherwise the line is left released.

A status read is a level strobe that can last several clocks. While it is high, the status byte stays frozen, and any event that arrives is parked. On the first clock after the strobe drops, every flag is cleared and the parked events are merged back in.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: An alarm byte with bits [7:6] equal to 2'b11 matches every value of its time field.
- R2: The alarm flag (status bit 5) sets on a clock where `upd_done` is 1 and all three fields match. A field matches when it equals its alarm byte or its alarm byte is a wildcard. A mismatch in any field, or a match without `upd_done`, leaves the flag clear. `upd_done` always sets the update flag (status bit 4).
- R3: Status bit layout:
  - bit 7 is the summary interrupt bit;
  - bit 6 is the periodic flag;
  - bit 5 is the alarm flag;
  - bit 4 is the update flag;
  - bits 3:0 always read 0.

  Control bit layout:
  - bit 7 is the hold bit;
  - bit 6 enables the periodic event;
  - bit 5 enables the alarm event;
  - bit 4 enables the update event;
  - bit 3 enables the square wave;
  - bits 2:0 always read 0.
- R4: An event flag sets one clock after its strobe, whether or not its enable is set. A flag whose enable is clear leaves `irq_pull_low` at 0.
- R5: Status bit 7 and `irq_pull_low` are 1 exactly when some flag and its enable are both 1.
- R6: Writing an enable bit while its flag is already set raises `irq_pull_low` on the clock after the write.
- R7: While `rd_stat` is high, `stat_q` holds the value it had when the read began. On the first clock that samples `rd_stat` low, every flag and the summary bit clear.
- R8: Events that arrive while `rd_stat` is high are held. They appear in the flags on the clock that ends the read.
- R9: Synchronous reset clears the three event enables, the square-wave enable, every flag and the summary bit, and releases the interrupt.
- R10: A control write with bit 7 set clears the update-event enable, whatever value is written in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| per_evt | input | 1 | One-clock periodic tick |
| upd_done | input | 1 | One-clock end-of-update strobe |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 alarm seconds, 1 alarm minutes, 2 alarm hours, 3 control |
| wr_data | input | 8 | Write data |
| rd_stat | input | 1 | Status read strobe, level, may span many clocks |
| stat_q | output | 8 | Status byte |
| ctrl_q | output | 8 | Control byte readback |
| irq_pull_low | output | 1 | 1 = drive the interrupt line low, 0 = release |

## Verification
The bench sends an update strobe in the middle of a long status read. A design that does not freeze the status byte shows the new flag early. A design that does not park the event loses it when the read-clear runs.

The bench also tests a match with no update strobe, a single-field mismatch, and wildcards in each field. A comparator that ignores the wildcard, or that fires without `upd_done`, gives the wrong alarm flag.

Finally, the bench raises an enable while its flag is already pending, and writes the hold bit together with the update enable. A design that registers enables one clock late misses the interrupt on the expected clock. A design that omits the hold-bit rule leaves the update enable set.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int ADDR_W = 2;
  localparam int NFIELD = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_ASEC = 2'd0,
    SEL_AMIN = 2'd1,
    SEL_AHR  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // field order matches status bits 6,5,4
  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } evt_t;

  localparam int CB_HOLD = 7;
  localparam int CB_PER  = 6;
  localparam int CB_ALM  = 5;
  localparam int CB_UPD  = 4;
  localparam int CB_SQW  = 3;
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] alarm_b,
  input  logic [DW-1:0] time_b,
  output logic          hit
);
  localparam logic [1:0] WILD = 2'b11;

  logic wild;
  assign wild = (alarm_b[DW-1:DW-2] == WILD);
  assign hit  = wild || (alarm_b == time_b);
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import alarm_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DW-1:0]             wr_data,
  output logic [NFIELD-1:0][DW-1:0] alarm_q,
  output evt_t                      en_q,
  output evt_t                      en_n,
  output logic                      hold_q,
  output logic                      sqw_q
);
  logic ctrl_wr;
  logic hold_n, sqw_n;

  assign ctrl_wr = wr_en && (wr_addr == SEL_CTRL);

  genvar gi;
  generate
    for (gi = 0; gi < NFIELD; gi++) begin : g_alarm
      always_ff @(posedge clk) begin
        if (rst)
          alarm_q[gi] <= '0;
        else if (wr_en && (wr_addr == ADDR_W'(gi)))
          alarm_q[gi] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    en_n   = en_q;
    hold_n = hold_q;
    sqw_n  = sqw_q;
    if (ctrl_wr) begin
      hold_n  = wr_data[CB_HOLD];
      en_n.per = wr_data[CB_PER];
      en_n.alm = wr_data[CB_ALM];
      en_n.upd = wr_data[CB_UPD] & ~wr_data[CB_HOLD];
      sqw_n   = wr_data[CB_SQW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      hold_q <= 1'b0;
      sqw_q  <= 1'b0;
    end else begin
      en_q   <= en_n;
      hold_q <= hold_n;
      sqw_q  <= sqw_n;
    end
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import alarm_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  evt_t          ev,
  input  evt_t          en_n,
  input  logic          rd_stat,
  output logic [DW-1:0] stat_q,
  output logic          irq_q
);
  localparam int PAD_W = DW - 4;

  evt_t flg_q, flg_n, pnd_q, pnd_n;
  logic rd_d, rd_end, irqf_n;

  assign rd_end = rd_d & ~rd_stat;

  always_comb begin
    if (rd_stat) begin
      flg_n = flg_q;
      pnd_n = pnd_q | ev;
    end else if (rd_end) begin
      flg_n = pnd_q | ev;
      pnd_n = '0;
    end else begin
      flg_n = flg_q | ev;
      pnd_n = '0;
    end
    irqf_n = |(flg_n & en_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q  <= '0;
      pnd_q  <= '0;
      rd_d   <= 1'b0;
      irq_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      flg_q <= flg_n;
      pnd_q <= pnd_n;
      rd_d  <= rd_stat;
      irq_q <= irqf_n;
      if (!rd_stat)
        stat_q <= {irqf_n, flg_n, {PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              per_evt,
  input  logic              upd_done,
  input  logic [DW-1:0]     cur_sec,
  input  logic [DW-1:0]     cur_min,
  input  logic [DW-1:0]     cur_hr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_stat,
  output logic [DW-1:0]     stat_q,
  output logic [DW-1:0]     ctrl_q,
  output logic              irq_pull_low
);
  localparam int CPAD_W = DW - 5;

  logic [NFIELD-1:0][DW-1:0] alarm_q;
  logic [NFIELD-1:0][DW-1:0] cur_t;
  logic [NFIELD-1:0]         hit;
  evt_t en_q, en_n, ev;
  logic hold_q, sqw_q;

  assign cur_t = {cur_hr, cur_min, cur_sec};

  irq_ctrl_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .alarm_q (alarm_q),
    .en_q    (en_q),
    .en_n    (en_n),
    .hold_q  (hold_q),
    .sqw_q   (sqw_q)
  );

  genvar gf;
  generate
    for (gf = 0; gf < NFIELD; gf++) begin : g_cmp
      alm_field_cmp #(.DW(DW)) u_cmp (
        .alarm_b (alarm_q[gf]),
        .time_b  (cur_t[gf]),
        .hit     (hit[gf])
      );
    end
  endgenerate

  assign ev.per = per_evt;
  assign ev.upd = upd_done;
  assign ev.alm = upd_done & (&hit);

  irq_flag_bank #(.DW(DW)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev),
    .en_n    (en_n),
    .rd_stat (rd_stat),
    .stat_q  (stat_q),
    .irq_q   (irq_pull_low)
  );

  assign ctrl_q = {hold_q, en_q.per, en_q.alm, en_q.upd, sqw_q, {CPAD_W{1'b0}}};
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          per_evt,
  input logic          upd_done,
  input logic          wr_ctrl,
  input logic          wr_hold,
  input logic          wr_per,
  input logic          rd_stat,
  input logic [DW-1:0] stat_q,
  input logic [DW-2:0] ctrl_lo,
  input logic          irq_pull_low
);
  // R3
  stat_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stat_q[3:0] == 4'b0);

  // R5
  irq_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_stat) |-> (irq_pull_low == stat_q[DW-1]));

  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && $past(rd_stat) && !$past(rst)) |-> $stable(stat_q));

  // R4
  per_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (per_evt && !rd_stat) |=> stat_q[DW-2]);

  // R8
  held_merge_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_stat) && upd_done) |=> stat_q[DW-4]);

  // R10
  hold_clears_upd_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wr_hold) |=> !ctrl_lo[4]);

  // R6
  en_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wr_per && stat_q[DW-2] && !rd_stat && !$past(rd_stat)) |=> irq_pull_low);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (stat_q == '0 && !irq_pull_low && ctrl_lo[6:3] == 4'b0));
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .per_evt      (per_evt),
  .upd_done     (upd_done),
  .wr_ctrl      (wr_en && (wr_addr == 2'd3)),
  .wr_hold      (wr_data[7]),
  .wr_per       (wr_data[6]),
  .rd_stat      (rd_stat),
  .stat_q       (stat_q),
  .ctrl_lo      (ctrl_q[DW-2:0]),
  .irq_pull_low (irq_pull_low)
);

// File: tb/alarm_irq_ctrl_bench.sv
module alarm_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       per_evt = 1'b0, upd_done = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hr = 8'h00;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_stat = 1'b0;
  logic [7:0] stat_q, ctrl_q;
  logic       irq_pull_low;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] st;
    logic       irq;
    logic [7:0] ct;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  alarm_irq_ctrl u_alarm_irq_ctrl (
    .clk(clk), .rst(rst), .per_evt(per_evt), .upd_done(upd_done),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stat(rd_stat), .stat_q(stat_q), .ctrl_q(ctrl_q),
    .irq_pull_low(irq_pull_low)
  );

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_run += 3;
      if (stat_q !== e.st) begin
        n_fail++;
        $display("FAIL %s stat_q actual %02h expected %02h", e.req, stat_q, e.st);
      end
      if (irq_pull_low !== e.irq) begin
        n_fail++;
        $display("FAIL %s irq_pull_low actual %0b expected %0b", e.req, irq_pull_low, e.irq);
      end
      if (ctrl_q !== e.ct) begin
        n_fail++;
        $display("FAIL %s ctrl_q actual %02h expected %02h", e.req, ctrl_q, e.ct);
      end
    end
  end

  // driver: push what the outputs must show after the coming rising edge
  task automatic cyc(input logic [7:0] st, input logic irq, input logic [7:0] ct,
                     input string req);
    exp_t e;
    @(posedge clk);
    #1;
    e.st = st; e.irq = irq; e.ct = ct; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [7:0] st,
                    input logic irq, input logic [7:0] ct, input string req);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(st, irq, ct, req);
    wr_en = 1'b0;
  endtask

  task automatic rd_clear(input logic [7:0] st, input logic irq, input logic [7:0] ct);
    rd_stat = 1'b1;
    cyc(st, irq, ct, "R7");
    rd_stat = 1'b0;
    cyc(8'h00, 1'b0, ct, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc(8'h00, 1'b0, 8'h00, "R9");

    // R4: flag without enable
    per_evt = 1'b1;
    cyc(8'h40, 1'b0, 8'h00, "R4");
    per_evt = 1'b0;
    // R6 / R3: enable with pending flag; low control bits dropped
    wr(2'd3, 8'h47, 8'hC0, 1'b1, 8'h40, "R6");

    // R7 / R8: frozen snapshot, held event
    cur_sec = 8'h05; cur_min = 8'h34; cur_hr = 8'h12;
    rd_stat = 1'b1;
    cyc(8'hC0, 1'b1, 8'h40, "R7");
    upd_done = 1'b1;
    cyc(8'hC0, 1'b1, 8'h40, "R7");
    upd_done = 1'b0; rd_stat = 1'b0;
    cyc(8'h10, 1'b0, 8'h40, "R8");
    rd_clear(8'h10, 1'b0, 8'h40);

    // R2: exact alarm
    wr(2'd0, 8'h30, 8'h00, 1'b0, 8'h40, "R2");
    wr(2'd1, 8'h15, 8'h00, 1'b0, 8'h40, "R2");
    wr(2'd2, 8'h08, 8'h00, 1'b0, 8'h40, "R2");
    cur_hr = 8'h08; cur_min = 8'h15; cur_sec = 8'h30;
    cyc(8'h00, 1'b0, 8'h40, "R2");
    upd_done = 1'b1;
    cyc(8'h30, 1'b0, 8'h40, "R2");
    upd_done = 1'b0;
    rd_clear(8'h30, 1'b0, 8'h40);
    cur_sec = 8'h31; upd_done = 1'b1;
    cyc(8'h10, 1'b0, 8'h40, "R2");
    upd_done = 1'b0;
    rd_clear(8'h10, 1'b0, 8'h40);

    // R1: wildcards
    wr(2'd0, 8'hC0, 8'h00, 1'b0, 8'h40, "R1");
    wr(2'd1, 8'hFF, 8'h00, 1'b0, 8'h40, "R1");
    cur_min = 8'h42; cur_sec = 8'h17; upd_done = 1'b1;
    cyc(8'h30, 1'b0, 8'h40, "R1");
    upd_done = 1'b0;
    rd_clear(8'h30, 1'b0, 8'h40);
    wr(2'd2, 8'hC5, 8'h00, 1'b0, 8'h40, "R1");
    cur_hr = 8'h23; upd_done = 1'b1;
    cyc(8'h30, 1'b0, 8'h40, "R1");
    upd_done = 1'b0;

    // R5 / R10 / R6
    wr(2'd3, 8'h30, 8'hB0, 1'b1, 8'h30, "R5");
    wr(2'd3, 8'h90, 8'h30, 1'b0, 8'h80, "R10");
    wr(2'd3, 8'h10, 8'hB0, 1'b1, 8'h10, "R6");
    wr(2'd3, 8'h18, 8'hB0, 1'b1, 8'h18, "R5");

    // R9: reset clears enables, square wave, flags
    rst = 1'b1;
    cyc(8'h00, 1'b0, 8'h00, "R9");
    rst = 1'b0;
    cyc(8'h00, 1'b0, 8'h00, "R9");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule